// File: doc/BRIEF.md
# Raster Sync and Frame Timing Generator

This block paces a raster display. It runs a horizontal position counter and a line counter. From those counters it produces an active-low line sync, an active-low frame sync, and a frame interrupt flag. Each line is 1024 clock positions long and each frame is 312 lines long. The frame sync is released part way through a line instead of at a line boundary.

Two window flags mark where pixel data is fetched and where pixels are shown. Both flags are decoded directly from the counters. The shown window trails the fetch window by a fixed number of positions. The number of lines in both windows depends on a text-row layout select: a layout of many short rows fills the full 256 lines, and a layout of fewer, taller rows leaves a few lines unused. The interrupt flag rises when the line after the largest possible active area begins. It stays high until the next frame starts, so software has the whole blanking interval to act on it.

All outputs are plain control signals and carry no flow control. All timing constants are parameters.

Top module: `raster_timing_gen`

## Requirements
- R1: `x_pos` counts up by one each clock from 0 to 1023 and then returns to 0. `y_pos` increments when `x_pos` wraps, and goes from 311 back to 0.
- R2: While `rst` is high, and on the first clock after it falls, `x_pos` and `y_pos` read 0, `hsync_n` and `vsync_n` are high, and `vsync_irq` is low.
- R3: `hsync_n` is low exactly when the position one clock earlier was in the range 0 to 63. The sync output therefore lags the counters by one clock.
- R4: `vsync_n` is low exactly when the position one clock earlier was line 0 or line 1, or was line 2 with a position below 512. It also lags the counters by one clock.
- R5: `vsync_irq` rises one clock after the counters read line 284, position 0. It falls one clock after they read line 0, position 0. It is therefore high for exactly 28 × 1024 clocks per frame.
- R6: `fetch_win` is high when `x_pos` is in the range 256 to 895 and `y_pos` is at least 28 and below 28 plus the active height.
- R7: `disp_win` covers the same lines as `fetch_win`, with the position range shifted 8 later (264 to 903).
- R8: `row_mode` = 0 selects 32 rows of 8 lines, for an active height of 256. `row_mode` = 1 selects 25 rows of 10 lines, for an active height of 250. The select takes effect on the window flags at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one raster position per cycle |
| rst | input | 1 | Synchronous reset, active high |
| row_mode | input | 1 | Row layout select: 0 = 32 rows, 1 = 25 rows |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| x_pos | output | 10 | Position within the line |
| y_pos | output | 9 | Line within the frame |
| fetch_win | output | 1 | Pixel fetch window |
| disp_win | output | 1 | Pixel display window |
| vsync_irq | output | 1 | End-of-active-area interrupt flag |

## Verification
The bench builds the generator with shortened lines and frames. It then sweeps every position of several whole frames, comparing each output against values worked out arithmetically from the counter positions. Full frames run in both row layouts. The counts of fetch-window cycles differ between the two layouts, which confirms that the layout select changes the active height and nothing else. A reset applied in the middle of a frame shows that all state restarts cleanly. Counting the interrupt-high cycles per frame separates a flag that is cleared at the frame start from one that is cleared at the sync edge or one that never clears.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic {
    ROWS_DENSE  = 1'b0,
    ROWS_SPACED = 1'b1
  } row_mode_e;
endpackage

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int LINE_LEN    = 1024,
  parameter int FRAME_LINES = 312,
  parameter int XW          = $clog2(LINE_LEN),
  parameter int YW          = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] x_cnt,
  output logic [YW-1:0] y_cnt
);
  localparam logic [XW-1:0] X_LAST = XW'(LINE_LEN - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(FRAME_LINES - 1);

  logic line_wrap;
  assign line_wrap = (x_cnt == X_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_cnt <= '0;
      y_cnt <= '0;
    end else begin
      x_cnt <= line_wrap ? '0 : x_cnt + 1'b1;
      if (line_wrap)
        y_cnt <= (y_cnt == Y_LAST) ? '0 : y_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/raster_sync.sv
module raster_sync #(
  parameter int XW       = 10,
  parameter int YW       = 9,
  parameter int HS_END   = 64,
  parameter int VS_LINE  = 2,
  parameter int VS_POS   = 512,
  parameter int IRQ_LINE = 284
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] x_cnt,
  input  logic [YW-1:0] y_cnt,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          irq
);
  localparam logic [XW-1:0] HS_X  = XW'(HS_END);
  localparam logic [XW-1:0] VS_X  = XW'(VS_POS);
  localparam logic [YW-1:0] VS_Y  = YW'(VS_LINE);
  localparam logic [YW-1:0] IRQ_Y = YW'(IRQ_LINE);

  logic hs_on, vs_on, line_start;

  always_comb begin
    line_start = (x_cnt == '0);
    hs_on      = (x_cnt < HS_X);
    vs_on      = (y_cnt < VS_Y) || ((y_cnt == VS_Y) && (x_cnt < VS_X));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      irq     <= 1'b0;
    end else begin
      hsync_n <= ~hs_on;
      vsync_n <= ~vs_on;
      if (line_start && (y_cnt == IRQ_Y))
        irq <= 1'b1;
      else if (line_start && (y_cnt == '0))
        irq <= 1'b0;
    end
  end
endmodule

// File: rtl/raster_window.sv
module raster_window
  import raster_pkg::*;
#(
  parameter int XW         = 10,
  parameter int YW         = 9,
  parameter int PIX_START  = 256,
  parameter int PIX_WIDTH  = 640,
  parameter int DISP_DELAY = 8,
  parameter int FIRST_LINE = 28,
  parameter int MAX_HEIGHT = 256,
  parameter int ROWS_A     = 32,
  parameter int ROWS_B     = 25
) (
  input  logic          row_mode,
  input  logic [XW-1:0] x_cnt,
  input  logic [YW-1:0] y_cnt,
  output logic          fetch_win,
  output logic          disp_win
);
  localparam int HEIGHT_A = (MAX_HEIGHT / ROWS_A) * ROWS_A;
  localparam int HEIGHT_B = (MAX_HEIGHT / ROWS_B) * ROWS_B;
  localparam logic [YW-1:0] Y_FIRST = YW'(FIRST_LINE);
  localparam logic [YW-1:0] Y_END_A = YW'(FIRST_LINE + HEIGHT_A);
  localparam logic [YW-1:0] Y_END_B = YW'(FIRST_LINE + HEIGHT_B);
  localparam int NWIN = 2;

  row_mode_e     mode;
  logic [YW-1:0] y_end;
  logic          in_lines;
  logic [NWIN-1:0] span;

  always_comb begin
    mode     = row_mode_e'(row_mode);
    y_end    = (mode == ROWS_SPACED) ? Y_END_B : Y_END_A;
    in_lines = (y_cnt >= Y_FIRST) && (y_cnt < y_end);
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [XW-1:0] X_LO = XW'(PIX_START + w * DISP_DELAY);
    localparam logic [XW-1:0] X_HI = XW'(PIX_START + PIX_WIDTH + w * DISP_DELAY);
    assign span[w] = in_lines && (x_cnt >= X_LO) && (x_cnt < X_HI);
  end

  assign fetch_win = span[0];
  assign disp_win  = span[1];
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int LINE_LEN    = 1024,
  parameter int FRAME_LINES = 312,
  parameter int HS_END      = 64,
  parameter int VS_LINE     = 2,
  parameter int VS_POS      = 512,
  parameter int PIX_START   = 256,
  parameter int PIX_WIDTH   = 640,
  parameter int DISP_DELAY  = 8,
  parameter int FIRST_LINE  = 28,
  parameter int MAX_HEIGHT  = 256,
  parameter int ROWS_A      = 32,
  parameter int ROWS_B      = 25,
  parameter int XW          = $clog2(LINE_LEN),
  parameter int YW          = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_mode,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic [XW-1:0] x_pos,
  output logic [YW-1:0] y_pos,
  output logic          fetch_win,
  output logic          disp_win,
  output logic          vsync_irq
);
  localparam int IRQ_LINE = FIRST_LINE + MAX_HEIGHT;

  raster_counters #(
    .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .XW(XW), .YW(YW)
  ) u_cnt (
    .clk(clk), .rst(rst), .x_cnt(x_pos), .y_cnt(y_pos)
  );

  raster_sync #(
    .XW(XW), .YW(YW), .HS_END(HS_END), .VS_LINE(VS_LINE),
    .VS_POS(VS_POS), .IRQ_LINE(IRQ_LINE)
  ) u_sync (
    .clk(clk), .rst(rst), .x_cnt(x_pos), .y_cnt(y_pos),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .irq(vsync_irq)
  );

  raster_window #(
    .XW(XW), .YW(YW), .PIX_START(PIX_START), .PIX_WIDTH(PIX_WIDTH),
    .DISP_DELAY(DISP_DELAY), .FIRST_LINE(FIRST_LINE), .MAX_HEIGHT(MAX_HEIGHT),
    .ROWS_A(ROWS_A), .ROWS_B(ROWS_B)
  ) u_win (
    .row_mode(row_mode), .x_cnt(x_pos), .y_cnt(y_pos),
    .fetch_win(fetch_win), .disp_win(disp_win)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int LINE_LEN    = 1024,
  parameter int FRAME_LINES = 312,
  parameter int HS_END      = 64,
  parameter int VS_LINE     = 2,
  parameter int VS_POS      = 512,
  parameter int FIRST_LINE  = 28,
  parameter int MAX_HEIGHT  = 256,
  parameter int XW          = 10,
  parameter int YW          = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic [XW-1:0] x_pos,
  input logic [YW-1:0] y_pos,
  input logic          fetch_win,
  input logic          disp_win,
  input logic          vsync_irq
);
  localparam logic [XW-1:0] X_LAST = XW'(LINE_LEN - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(FRAME_LINES - 1);
  localparam logic [XW-1:0] HS_X   = XW'(HS_END);
  localparam logic [XW-1:0] VS_X   = XW'(VS_POS);
  localparam logic [YW-1:0] VS_Y   = YW'(VS_LINE);
  localparam logic [YW-1:0] IRQ_Y  = YW'(FIRST_LINE + MAX_HEIGHT);
  localparam logic [YW-1:0] Y_LO   = YW'(FIRST_LINE);

  // R1
  x_step_chk: assert property (@(posedge clk) disable iff (rst)
    (x_pos != X_LAST) |=> (x_pos == $past(x_pos) + 1'b1));
  // R1
  y_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (x_pos == X_LAST && y_pos == Y_LAST) |=> (x_pos == '0 && y_pos == '0));
  // R1
  y_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (x_pos != X_LAST) |=> $stable(y_pos));
  // R3
  hs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (x_pos == '0) |=> !hsync_n);
  // R3
  hs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (x_pos == HS_X) |=> hsync_n);
  // R4
  vs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (x_pos == '0 && y_pos == '0) |=> !vsync_n);
  // R4
  vs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (x_pos == VS_X && y_pos == VS_Y) |=> vsync_n);
  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (x_pos == '0 && y_pos == IRQ_Y) |=> vsync_irq);
  // R5
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (x_pos == '0 && y_pos == '0) |=> !vsync_irq);
  // R6
  fetch_lines_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_win |-> (y_pos >= Y_LO && y_pos < IRQ_Y));
  // R7
  disp_lines_chk: assert property (@(posedge clk) disable iff (rst)
    disp_win |-> (y_pos >= Y_LO && y_pos < IRQ_Y));
endmodule

bind raster_timing_gen raster_timing_chk #(
  .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .HS_END(HS_END),
  .VS_LINE(VS_LINE), .VS_POS(VS_POS), .FIRST_LINE(FIRST_LINE),
  .MAX_HEIGHT(MAX_HEIGHT), .XW(XW), .YW(YW)
) u_chk (
  .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .x_pos(x_pos), .y_pos(y_pos), .fetch_win(fetch_win),
  .disp_win(disp_win), .vsync_irq(vsync_irq)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  localparam int LL  = 64;
  localparam int FL  = 40;
  localparam int HS  = 8;
  localparam int VL  = 2;
  localparam int VP  = 32;
  localparam int PS  = 16;
  localparam int PW  = 40;
  localparam int DD  = 2;
  localparam int F0  = 4;
  localparam int MH  = 32;
  localparam int RA  = 8;
  localparam int RB  = 5;
  localparam int IRQ = F0 + MH;
  localparam int XW  = $clog2(LL);
  localparam int YW  = $clog2(FL);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_mode = 1'b0;
  logic hsync_n, vsync_n, fetch_win, disp_win, vsync_irq;
  logic [XW-1:0] x_pos;
  logic [YW-1:0] y_pos;

  raster_timing_gen #(
    .LINE_LEN(LL), .FRAME_LINES(FL), .HS_END(HS), .VS_LINE(VL), .VS_POS(VP),
    .PIX_START(PS), .PIX_WIDTH(PW), .DISP_DELAY(DD), .FIRST_LINE(F0),
    .MAX_HEIGHT(MH), .ROWS_A(RA), .ROWS_B(RB)
  ) u_raster_timing_gen (
    .clk(clk), .rst(rst), .row_mode(row_mode), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .x_pos(x_pos), .y_pos(y_pos), .fetch_win(fetch_win),
    .disp_win(disp_win), .vsync_irq(vsync_irq)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int xe = 0, ye = 0;
  bit hse = 1, vse = 1, irqe = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (x=%0d y=%0d)", req, act, exp, xe, ye);
    end
  endtask

  function automatic int height(input bit m);
    return m ? (MH / RB) * RB : (MH / RA) * RA;
  endfunction

  task automatic compare();
    int h;
    bit inl, fe, de;
    h   = height(row_mode);
    inl = (ye >= F0) && (ye < F0 + h);
    fe  = inl && (xe >= PS) && (xe < PS + PW);
    de  = inl && (xe >= PS + DD) && (xe < PS + PW + DD);
    chk("R1 x_pos", int'(x_pos), xe);
    chk("R1 y_pos", int'(y_pos), ye);
    chk("R3 hsync_n", int'(hsync_n), int'(hse));
    chk("R4 vsync_n", int'(vsync_n), int'(vse));
    chk("R5 vsync_irq", int'(vsync_irq), int'(irqe));
    chk("R6 fetch_win", int'(fetch_win), int'(fe));
    chk("R7 disp_win", int'(disp_win), int'(de));
  endtask

  // one clock edge, model update, sample at the falling edge
  task automatic step();
    @(posedge clk);
    if (rst) begin
      xe = 0; ye = 0; hse = 1; vse = 1; irqe = 0;
    end else begin
      hse = !(xe < HS);
      vse = !((ye < VL) || (ye == VL && xe < VP));
      if (xe == 0 && ye == IRQ) irqe = 1;
      else if (xe == 0 && ye == 0) irqe = 0;
      if (xe == LL - 1) begin
        xe = 0;
        ye = (ye == FL - 1) ? 0 : ye + 1;
      end else begin
        xe = xe + 1;
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic run_frame();
    int nfetch = 0, nirq = 0;
    for (int i = 0; i < LL * FL; i++) begin
      step();
      nfetch += int'(fetch_win);
      nirq   += int'(vsync_irq);
    end
    // R8 active height per layout; R5 interrupt length
    chk("R8 fetch cycles per frame", nfetch, PW * height(row_mode));
    chk("R5 irq cycles per frame", nirq, (FL - IRQ) * LL);
  endtask

  initial begin
    @(negedge clk);
    // R2 reset state
    for (int i = 0; i < 3; i++) step();
    chk("R2 reset hsync_n", int'(hsync_n), 1);
    chk("R2 reset vsync_n", int'(vsync_n), 1);
    chk("R2 reset irq", int'(vsync_irq), 0);
    rst = 1'b0;
    run_frame();
    run_frame();
    row_mode = 1'b1;   // R8 spaced rows
    run_frame();
    run_frame();
    row_mode = 1'b0;
    for (int i = 0; i < 2500; i++) step();
    rst = 1'b1;        // R2 mid-frame reset
    step();
    step();
    chk("R2 mid-frame reset x", int'(x_pos), 0);
    chk("R2 mid-frame reset y", int'(y_pos), 0);
    chk("R2 mid-frame reset irq", int'(vsync_irq), 0);
    rst = 1'b0;
    run_frame();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule